// File: doc/BRIEF.md
# Per-Key Touch Detection Processor

This block turns the raw acquisition counts of one capacitive sensing channel into a debounced touch decision. Each time a new count arrives, the block compares it with a stored reference level. The signed difference, reference minus sample, is positive when the electrode load rises (a finger lowers the count). A touch is accepted only after a run of qualifying samples. A release is judged against a lower level, which gives hysteresis, and it also needs its own run of samples. A fast setting shortens both runs.

The reference is not fixed. While the channel is idle, it creeps one count at a time toward the sample, and it moves faster when the sample is above it than when it is below. Two conditions make the channel recalibrate on its own, which sets the reference to the most recent sample:
- a touch that outlasts a selectable maximum duration;
- a sample that stays well on the wrong side of the reference for a fixed time.

All times are counted in millisecond ticks supplied by the surrounding chip. One instance serves one key.

Top module: `touch_key_proc`

## Requirements
- R1: After reset `touched_o` is 0 and `delta_o` is 0. The first valid sample after reset loads the reference. From then on `delta_o` equals reference minus the last accepted sample, as a signed SW+1-bit value.
- R2: While untouched, a sample counts toward a touch only if its delta is at least 10. A delta of 9 never produces a touch.
- R3: With `fast_mode_i`=0, `touched_o` rises on the 6th consecutive qualifying sample.
- R4: While touched, a sample counts toward release only if its delta is below 8 (threshold minus 2 of hysteresis). Deltas of 8 and 9 keep the key touched.
- R5: With `fast_mode_i`=0, `touched_o` falls on the 3rd consecutive release sample.
- R6: With `fast_mode_i`=1, a touch needs 3 consecutive qualifying samples and a release needs 2.
- R7: A sample that fails the current condition clears the run, so counting restarts from zero.
- R8: `timeout_sel_i`=0 selects a limit of ON_SHORT_MS ticks (10000 by default), 1 selects ON_LONG_MS (60000), and 2 or 3 disables the limit. On the tick that completes the limit while touched, the reference takes the last sample and `touched_o` clears.
- R9: While the delta is -6 or lower, ticks are counted. On the NEG_MS-th consecutive such tick (2000 by default), the reference takes the last sample. If the condition ends, the count restarts.
- R10: While untouched and not confirming, the reference steps one count toward the sample. It steps every DRIFT_UP_MS ticks (2000) when the delta is positive and every DRIFT_DN_MS ticks (500) when the delta is negative.
- R11: The drift of R10 is frozen while the key is touched or has a touch run in progress.
- R12: The confirmation count never exceeds its limit and never wraps. If fast mode is selected while the count already meets the fast limit, the next qualifying sample completes the transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | SW | Raw acquisition count for this channel |
| sample_valid_i | input | 1 | One-cycle strobe marking a new sample |
| ms_tick_i | input | 1 | One-cycle strobe once per millisecond |
| fast_mode_i | input | 1 | 1 = short confirmation runs |
| timeout_sel_i | input | 2 | Maximum touch duration select (see R8) |
| touched_o | output | 1 | Debounced touch state |
| delta_o | output | SW+1 | Signed reference minus last sample |

## Verification
Three timing mechanisms act on the same reference register: drift, reverse-direction recalibration and the touch-duration limit. The hardest case to reach is the tick on which several of them want to act at once. A large negative step is held while drift shortens the gap every few ticks, so the wrong-direction timer and drift both fire on the same tick. The bench shrinks every millisecond constant so that these coincidences can be reached, and it predicts the delta at each tick by integer division of the tick count.

// File: rtl/tkp_pkg.sv
`timescale 1ns/1ps
package tkp_pkg;

    typedef enum logic [1:0] {
        TMO_SHORT = 2'd0,
        TMO_LONG  = 2'd1,
        TMO_OFF   = 2'd2,
        TMO_OFF2  = 2'd3
    } tmo_sel_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tkp_confirm.sv
`timescale 1ns/1ps
module tkp_confirm
    import tkp_pkg::*;
#(
    parameter int DW        = 9,
    parameter int TH        = 10,
    parameter int HYST      = 2,
    parameter int N_TOUCH   = 6,
    parameter int N_RELEASE = 3,
    parameter int F_TOUCH   = 3,
    parameter int F_RELEASE = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 eval_i,
    input  logic signed [DW-1:0] delta_i,
    input  logic                 fast_i,
    input  logic                 clear_i,
    output logic                 touched_o,
    output logic                 confirming_o
);

    localparam int CNT_MAX = max2(max2(N_TOUCH, N_RELEASE), max2(F_TOUCH, F_RELEASE));
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int REL_LVL = TH - HYST;

    typedef struct packed {
        logic          touched;
        logic [CW-1:0] cnt;
    } conf_t;

    conf_t state_d, state_q;
    int    lim;
    logic  cond;

    always_comb begin
        state_d = state_q;
        if (state_q.touched) begin
            lim  = fast_i ? F_RELEASE : N_RELEASE;
            cond = (delta_i < REL_LVL);
        end else begin
            lim  = fast_i ? F_TOUCH : N_TOUCH;
            cond = (delta_i >= TH);
        end
        if (clear_i) begin
            state_d = '0;
        end else if (eval_i) begin
            if (cond) begin
                if (int'(state_q.cnt) + 1 >= lim) begin
                    state_d.touched = !state_q.touched;
                    state_d.cnt     = '0;
                end else begin
                    state_d.cnt = state_q.cnt + 1'b1;
                end
            end else begin
                state_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign touched_o    = state_q.touched;
    assign confirming_o = !state_q.touched && (state_q.cnt != '0);

    // R12: run count stays below the largest limit
    a_r12_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(state_q.cnt) < CNT_MAX);

    // R2: a touch is only entered on an evaluated sample above threshold
    a_r2_touch_needs_press: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(state_q.touched) |-> $past(eval_i && (delta_i >= TH)));

    // R4: a release needs a sample below the hysteresis level, or a recalibration
    a_r4_release_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(state_q.touched) |-> $past(clear_i || (eval_i && (delta_i < REL_LVL))));

endmodule

// File: rtl/tkp_timers.sv
`timescale 1ns/1ps
module tkp_timers
    import tkp_pkg::*;
#(
    parameter int DW          = 9,
    parameter int NEG_TH      = 6,
    parameter int ON_SHORT_MS = 10000,
    parameter int ON_LONG_MS  = 60000,
    parameter int NEG_MS      = 2000,
    parameter int DRIFT_UP_MS = 2000,
    parameter int DRIFT_DN_MS = 500
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 tick_i,
    input  logic                 ref_valid_i,
    input  logic                 touched_i,
    input  logic                 confirming_i,
    input  logic signed [DW-1:0] delta_i,
    input  logic [1:0]           tmo_sel_i,
    output logic                 recal_o,
    output logic                 ref_dec_o,
    output logic                 ref_inc_o
);

    localparam int ON_MAX = max2(ON_SHORT_MS, ON_LONG_MS);
    localparam int ON_W   = $clog2(ON_MAX + 1);
    localparam int NEG_W  = $clog2(NEG_MS + 1);
    localparam int DR_MAX = max2(DRIFT_UP_MS, DRIFT_DN_MS);
    localparam int DR_W   = $clog2(DR_MAX + 1);

    typedef struct packed {
        logic [ON_W-1:0]  on;
        logic [NEG_W-1:0] neg;
        logic [DR_W-1:0]  up;
        logic [DR_W-1:0]  dn;
    } tmr_t;

    tmr_t     tmr_d, tmr_q;
    tmo_sel_e sel;
    logic     on_en, on_hit, neg_hit, neg_cond, below, above, drift_act;
    int       on_lim;

    always_comb begin
        sel       = tmo_sel_e'(tmo_sel_i);
        on_en     = (sel == TMO_SHORT) || (sel == TMO_LONG);
        on_lim    = (sel == TMO_SHORT) ? ON_SHORT_MS : ON_LONG_MS;
        neg_cond  = ref_valid_i && (delta_i <= -NEG_TH);
        below     = delta_i > 0;
        above     = delta_i < 0;
        drift_act = ref_valid_i && !touched_i && !confirming_i;

        on_hit  = tick_i && touched_i && on_en && (int'(tmr_q.on) + 1 >= on_lim);
        neg_hit = tick_i && neg_cond && (int'(tmr_q.neg) + 1 >= NEG_MS);
        recal_o = on_hit || neg_hit;

        tmr_d     = tmr_q;
        ref_dec_o = 1'b0;
        ref_inc_o = 1'b0;

        if (!touched_i)               tmr_d.on = '0;
        else if (tick_i && on_en)     tmr_d.on = tmr_q.on + 1'b1;

        if (!neg_cond)                tmr_d.neg = '0;
        else if (tick_i)              tmr_d.neg = tmr_q.neg + 1'b1;

        if (drift_act) begin
            if (!below) begin
                tmr_d.up = '0;
            end else if (tick_i) begin
                if (int'(tmr_q.up) + 1 >= DRIFT_UP_MS) begin
                    tmr_d.up  = '0;
                    ref_dec_o = 1'b1;
                end else begin
                    tmr_d.up = tmr_q.up + 1'b1;
                end
            end
            if (!above) begin
                tmr_d.dn = '0;
            end else if (tick_i) begin
                if (int'(tmr_q.dn) + 1 >= DRIFT_DN_MS) begin
                    tmr_d.dn  = '0;
                    ref_inc_o = 1'b1;
                end else begin
                    tmr_d.dn = tmr_q.dn + 1'b1;
                end
            end
        end

        if (recal_o) begin
            tmr_d     = '0;
            ref_dec_o = 1'b0;
            ref_inc_o = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    // R8: recalibration only ever happens on a millisecond tick
    a_r8_recal_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        recal_o |-> tick_i);

    // R9: the wrong-direction timer never passes its limit
    a_r9_neg_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(tmr_q.neg) < NEG_MS);

    // R10: drift never pulls both ways at once
    a_r10_one_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ref_dec_o && ref_inc_o));

endmodule

// File: rtl/touch_key_proc.sv
`timescale 1ns/1ps
module touch_key_proc #(
    parameter int SW          = 8,
    parameter int TH          = 10,
    parameter int HYST        = 2,
    parameter int NEG_TH      = 6,
    parameter int N_TOUCH     = 6,
    parameter int N_RELEASE   = 3,
    parameter int F_TOUCH     = 3,
    parameter int F_RELEASE   = 2,
    parameter int ON_SHORT_MS = 10000,
    parameter int ON_LONG_MS  = 60000,
    parameter int NEG_MS      = 2000,
    parameter int DRIFT_UP_MS = 2000,
    parameter int DRIFT_DN_MS = 500
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [SW-1:0]        sample_i,
    input  logic                 sample_valid_i,
    input  logic                 ms_tick_i,
    input  logic                 fast_mode_i,
    input  logic [1:0]           timeout_sel_i,
    output logic                 touched_o,
    output logic signed [SW:0]   delta_o
);

    localparam int DW = SW + 1;

    typedef struct packed {
        logic [SW-1:0] refv;
        logic [SW-1:0] last;
        logic          valid;
    } chan_t;

    chan_t                 state_d, state_q;
    logic signed [DW-1:0]  live_delta, held_delta;
    logic                  recal_w, dec_w, inc_w, confirming_w, eval_w;

    assign live_delta = $signed({1'b0, state_q.refv}) - $signed({1'b0, sample_i});
    assign held_delta = $signed({1'b0, state_q.refv}) - $signed({1'b0, state_q.last});
    assign eval_w     = sample_valid_i && state_q.valid && !recal_w;

    always_comb begin
        state_d = state_q;
        if (sample_valid_i && !state_q.valid) begin
            state_d.refv  = sample_i;
            state_d.last  = sample_i;
            state_d.valid = 1'b1;
        end else begin
            if (sample_valid_i) state_d.last = sample_i;
            if (recal_w)        state_d.refv = state_q.last;
            else if (dec_w)     state_d.refv = state_q.refv - 1'b1;
            else if (inc_w)     state_d.refv = state_q.refv + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    tkp_confirm #(
        .DW(DW), .TH(TH), .HYST(HYST),
        .N_TOUCH(N_TOUCH), .N_RELEASE(N_RELEASE),
        .F_TOUCH(F_TOUCH), .F_RELEASE(F_RELEASE)
    ) u_confirm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .eval_i       (eval_w),
        .delta_i      (live_delta),
        .fast_i       (fast_mode_i),
        .clear_i      (recal_w),
        .touched_o    (touched_o),
        .confirming_o (confirming_w)
    );

    tkp_timers #(
        .DW(DW), .NEG_TH(NEG_TH),
        .ON_SHORT_MS(ON_SHORT_MS), .ON_LONG_MS(ON_LONG_MS),
        .NEG_MS(NEG_MS), .DRIFT_UP_MS(DRIFT_UP_MS), .DRIFT_DN_MS(DRIFT_DN_MS)
    ) u_timers (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (ms_tick_i),
        .ref_valid_i  (state_q.valid),
        .touched_i    (touched_o),
        .confirming_i (confirming_w),
        .delta_i      (held_delta),
        .tmo_sel_i    (timeout_sel_i),
        .recal_o      (recal_w),
        .ref_dec_o    (dec_w),
        .ref_inc_o    (inc_w)
    );

    assign delta_o = held_delta;

    // R1: the reference is loaded from the first accepted sample
    a_r1_first_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(state_q.valid) |-> (state_q.refv == $past(sample_i)));

    // R11: no drift while touched or confirming
    a_r11_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((touched_o || confirming_w) && !recal_w) |=> $stable(state_q.refv));

    // R10: outside recalibration the reference moves at most one count
    a_r10_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.valid && !recal_w) |=>
            ((state_q.refv == $past(state_q.refv)) ||
             (state_q.refv == $past(state_q.refv) + 1'b1) ||
             (state_q.refv == $past(state_q.refv) - 1'b1)));

endmodule

// File: tb/test_touch_key_proc.sv
`timescale 1ns/1ps
module test_touch_key_proc;

    localparam int SW    = 8;
    localparam int ON_S  = 30;
    localparam int ON_L  = 70;
    localparam int NEG   = 12;
    localparam int DUP   = 8;
    localparam int DDN   = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [SW-1:0]      sample = '0;
    logic               valid = 1'b0;
    logic               tick = 1'b0;
    logic               fast = 1'b0;
    logic [1:0]         tsel = 2'd2;
    logic               touched;
    logic signed [SW:0] delta;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    touch_key_proc #(
        .SW(SW), .ON_SHORT_MS(ON_S), .ON_LONG_MS(ON_L),
        .NEG_MS(NEG), .DRIFT_UP_MS(DUP), .DRIFT_DN_MS(DDN)
    ) i_touch_key_proc (
        .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_valid_i(valid),
        .ms_tick_i(tick), .fast_mode_i(fast), .timeout_sel_i(tsel),
        .touched_o(touched), .delta_o(delta)
    );

    task automatic chk_t(input string tag, input logic exp);
        n_run++;
        if (touched !== exp) begin
            n_fail++;
            $display("FAIL %s touched: actual %0b expected %0b", tag, touched, exp);
        end
    endtask

    task automatic chk_d(input string tag, input int exp);
        n_run++;
        if (int'(delta) != exp) begin
            n_fail++;
            $display("FAIL %s delta: actual %0d expected %0d", tag, int'(delta), exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; valid = 1'b0; tick = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input int v);
        @(negedge clk);
        sample = v[SW-1:0]; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung, expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int dl[4] = '{9, 10, 11, 20};
        int rl[4] = '{9, 8, 7, 0};

        // R1: reset state and first load
        repeat (3) @(negedge clk);
        chk_t("R1", 1'b0);
        chk_d("R1", 0);
        rst_n = 1'b1;
        @(negedge clk);
        send(100);
        chk_d("R1", 0);
        send(95);
        chk_d("R1", 5);

        // R2 R3 R6: touch run length sweep
        for (int f = 0; f < 2; f++) begin
            for (int i = 0; i < 4; i++) begin
                int lim;
                lim = f ? 3 : 6;
                fast = f[0];
                tsel = 2'd2;
                do_reset();
                send(100);
                for (int k = 1; k <= 7; k++) begin
                    send(100 - dl[i]);
                    chk_t(dl[i] < 10 ? "R2" : (f ? "R6" : "R3"),
                          (dl[i] >= 10) && (k >= lim));
                    chk_d("R1", dl[i]);
                end
            end
        end

        // R4 R5 R6: release with hysteresis
        for (int f = 0; f < 2; f++) begin
            for (int i = 0; i < 4; i++) begin
                int tl, rlim;
                tl = f ? 3 : 6;
                rlim = f ? 2 : 3;
                fast = f[0];
                do_reset();
                send(100);
                for (int k = 0; k < tl; k++) send(88);
                chk_t(f ? "R6" : "R3", 1'b1);
                for (int k = 1; k <= 4; k++) begin
                    send(100 - rl[i]);
                    chk_t(rl[i] >= 8 ? "R4" : (f ? "R6" : "R5"),
                          !((rl[i] < 8) && (k >= rlim)));
                end
            end
        end
        fast = 1'b0;

        // R7: interrupted runs restart
        do_reset();
        send(100);
        for (int k = 0; k < 5; k++) send(88);
        send(95);
        chk_t("R7", 1'b0);
        for (int k = 0; k < 5; k++) send(88);
        chk_t("R7", 1'b0);
        send(88);
        chk_t("R7", 1'b1);
        send(97); send(97); send(88); send(97); send(97);
        chk_t("R7", 1'b1);
        send(97);
        chk_t("R7", 1'b0);

        // R12: switching to fast with a long run in progress
        do_reset();
        send(100);
        for (int k = 0; k < 5; k++) send(88);
        chk_t("R12", 1'b0);
        fast = 1'b1;
        send(88);
        chk_t("R12", 1'b1);
        fast = 1'b0;
        for (int k = 0; k < 8; k++) send(88);
        chk_t("R12", 1'b1);

        // R11: drift frozen while confirming and while touched
        do_reset();
        send(100);
        send(88);
        ticks(20);
        chk_d("R11", 12);
        chk_t("R11", 1'b0);
        for (int k = 0; k < 4; k++) send(88);
        chk_t("R7", 1'b0);
        send(88);
        chk_t("R11", 1'b1);
        ticks(50);
        chk_d("R11", 12);

        // R10: drift rates by direction
        do_reset();
        send(100);
        send(95);
        ticks(DUP - 1);
        chk_d("R10", 5);
        ticks(1);
        chk_d("R10", 4);
        ticks(DUP);
        chk_d("R10", 3);
        do_reset();
        send(100);
        send(104);
        ticks(DDN - 1);
        chk_d("R10", -4);
        ticks(1);
        chk_d("R10", -3);
        ticks(DDN);
        chk_d("R10", -2);
        ticks(2 * DDN);
        chk_d("R10", 0);
        ticks(5);
        chk_d("R10", 0);

        // R9: wrong-direction recalibration
        do_reset();
        send(100);
        send(120);
        ticks(NEG - 1);
        chk_d("R9", -20 + (NEG - 1) / DDN);
        ticks(1);
        chk_d("R9", 0);
        ticks(5);
        chk_d("R9", 0);
        do_reset();
        send(100);
        send(106);
        ticks(DDN - 1);
        chk_d("R9", -6);
        ticks(NEG - DDN + 1);
        chk_d("R9", -6 + NEG / DDN);

        // R8: maximum touch duration
        for (int s = 0; s < 3; s++) begin
            int lim;
            lim = (s == 0) ? ON_S : ON_L;
            tsel = (s == 2) ? 2'd3 : s[1:0];
            do_reset();
            send(100);
            for (int k = 0; k < 6; k++) send(88);
            chk_t("R8", 1'b1);
            if (s < 2) begin
                ticks(lim - 1);
                chk_t("R8", 1'b1);
                chk_d("R8", 12);
                ticks(1);
                chk_t("R8", 1'b0);
                chk_d("R8", 0);
                send(88);
                chk_d("R8", 0);
                chk_t("R8", 1'b0);
            end else begin
                ticks(150);
                chk_t("R8", 1'b1);
                chk_d("R8", 12);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule